// File: doc/BRIEF.md
# Companion-Chip GPIO and Control Register Block

This block is a memory-mapped register file for a companion chip in a handheld device. A host reaches it over a plain synchronous register bus with an address, write data, a write enable, a read enable and registered read data. The block decodes a 4 KB window and holds eight 16-bit control registers, one fixed status word and a 16-line GPIO port built from a direction register and a level register.

The GPIO port drives one output level per line. That level is the stored level masked by the direction register. It changes only when the host writes the direction or level register. When it changes, every line whose masked level differs from the last one driven gets a one-cycle change pulse. External sources can set or clear single level bits through a per-line update strobe. These updates change the stored level but do not move the outputs until the next direction or level write. The bus has no back-pressure. Every access completes in one cycle, so there is no valid/ready handshake. All pins are plain control and status signals.

The power register has a special write rule: when written bit 7 is set, two further bits are forced on. Writes to the level register only keep bits whose direction is set.

Top module: `comp_gpio_regs`

## Requirements
- R1: Word offsets select registers in this order: 0x00 mode, 0x04 card detect, 0x08 status, 0x0C power, 0x10 card control, 0x14 interrupt reset, 0x18 interrupt mask, 0x1C interrupt status, 0x20 GPIO direction, 0x24 GPIO level, 0x28 GPIO scratch read. Reading a writable offset returns its stored value. The level offset returns the stored level, including bits set by external inputs.
- R2: Every write stores only bits 15:0 of the 32-bit write data. The upper bits are discarded.
- R3: A power-register write with data bit 7 set stores the data ORed with 0x8040. Any other power write stores the data unchanged.
- R4: A level-register write stores the data ANDed with the current direction register.
- R5: After a write to direction or level, gpio_out becomes level AND direction at the next clock edge. For that one cycle, gpio_chg has a 1 on exactly the lines whose value differs from the previous gpio_out. Otherwise gpio_out holds and gpio_chg is 0.
- R6: After reset, status reads 0x0002 and every other register, gpio_out and gpio_chg read zero.
- R7: When ext_upd[N] is high for a cycle, level bit N takes ext_val[N], and gpio_out and gpio_chg do not move. A bus write to the level register in the same cycle overrides every external update.
- R8: A write to status, a write to an unmapped offset, or a write to a misaligned offset (low two bits non-zero) changes no state. A read of an unmapped or misaligned offset returns zero.
- R9: bus_rdata shows the addressed value one clock after a cycle with bus_re high, and holds its value while bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 16 | Registered read data |
| ext_upd | input | 16 | Per-line external level update strobe |
| ext_val | input | 16 | Per-line external level value |
| gpio_out | output | 16 | Driven GPIO level (level AND direction) |
| gpio_chg | output | 16 | One-cycle per-line change pulse |

## Verification
The assertions check every cycle that the driven outputs never show a bit outside the direction mask. They also check that change pulses are exactly the edges of gpio_out, that outputs stay still unless a direction or level write occurs, that level writes honour the mask, that the power rule forces its bits, and that unmapped reads return zero with read data held between reads. Only the bench scenarios show that the full register map reads back the right contents. The same holds for reset values across all offsets, discarded upper write bits, writes to status and unmapped offsets, and the precedence of a bus level write over a simultaneous external update.

// File: rtl/comp_regs_pkg.sv
package comp_regs_pkg;

  localparam int REG_W    = 16;
  localparam int NUM_REGS = 11;

  // Order equals word index of the register offset.
  typedef enum logic [3:0] {
    RID_MODE = 4'd0,
    RID_CDET = 4'd1,
    RID_STAT = 4'd2,
    RID_PWR  = 4'd3,
    RID_CCTL = 4'd4,
    RID_IRR  = 4'd5,
    RID_IMR  = 4'd6,
    RID_ISR  = 4'd7,
    RID_GDIR = 4'd8,
    RID_GLVL = 4'd9,
    RID_GRD  = 4'd10,
    RID_NONE = 4'd15
  } reg_id_e;

  localparam logic [REG_W-1:0] STAT_RESET   = 16'h0002;
  localparam int               PWR_TRIG_BIT = 7;
  localparam logic [REG_W-1:0] PWR_SET_MASK = 16'h8040;

endpackage

// File: rtl/cr_addr_dec.sv
module cr_addr_dec
  import comp_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           id
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    id = RID_NONE;
    if (addr[1:0] == 2'b00) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (word_idx == IDX_W'(k)) id = reg_id_e'(k);
      end
    end
  end
endmodule

// File: rtl/cr_ctrl_bank.sv
module cr_ctrl_bank
  import comp_regs_pkg::*;
#(
  parameter int               W        = 16,
  parameter int               TRIG_BIT = 7,
  parameter logic [W-1:0]     SET_MASK = 16'h8040
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_id_e      wr_id,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] cdet_q,
  output logic [W-1:0] pwr_q,
  output logic [W-1:0] cctl_q,
  output logic [W-1:0] irr_q,
  output logic [W-1:0] imr_q,
  output logic [W-1:0] isr_q,
  output logic [W-1:0] grd_q
);
  logic [W-1:0] pwr_nx;
  assign pwr_nx = wr_data[TRIG_BIT] ? (wr_data | SET_MASK) : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cdet_q <= '0;
      pwr_q  <= '0;
      cctl_q <= '0;
      irr_q  <= '0;
      imr_q  <= '0;
      isr_q  <= '0;
      grd_q  <= '0;
    end else if (wr_en) begin
      case (wr_id)
        RID_MODE: mode_q <= wr_data;
        RID_CDET: cdet_q <= wr_data;
        RID_PWR:  pwr_q  <= pwr_nx;
        RID_CCTL: cctl_q <= wr_data;
        RID_IRR:  irr_q  <= wr_data;
        RID_IMR:  imr_q  <= wr_data;
        RID_ISR:  isr_q  <= wr_data;
        RID_GRD:  grd_q  <= wr_data;
        default:  ;
      endcase
    end
  end

  // R3: trigger bit written forces the extra bits on
  a_r3_power_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_id == RID_PWR && wr_data[TRIG_BIT]) |=> ((pwr_q & SET_MASK) == SET_MASK));
endmodule

// File: rtl/cr_gpio_port.sv
module cr_gpio_port #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] ext_upd,
  input  logic [N-1:0] ext_val,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] gpio_out,
  output logic [N-1:0] gpio_chg
);
  logic [N-1:0] dir_nx;
  logic [N-1:0] lvl_nx;
  logic [N-1:0] eff_nx;
  logic         refresh;

  assign dir_nx  = dir_we ? wr_data : dir_q;
  assign refresh = dir_we | lvl_we;
  assign eff_nx  = lvl_nx & dir_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_nx;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    // Bus level write takes precedence over an external update.
    always_comb begin
      if (lvl_we)          lvl_nx[i] = wr_data[i] & dir_q[i];
      else if (ext_upd[i]) lvl_nx[i] = ext_val[i];
      else                 lvl_nx[i] = lvl_q[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q[i]    <= 1'b0;
        gpio_out[i] <= 1'b0;
        gpio_chg[i] <= 1'b0;
      end else begin
        lvl_q[i]    <= lvl_nx[i];
        gpio_chg[i] <= refresh & (eff_nx[i] ^ gpio_out[i]);
        if (refresh) gpio_out[i] <= eff_nx[i];
      end
    end
  end

  // R4: stored level holds no bit outside the direction at the time of the write
  a_r4_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> ((lvl_q & ~$past(dir_q)) == '0));

  // R5: driven outputs stay inside the direction mask
  a_r5_out_in_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out & ~dir_q) == '0));

  // R5: change pulses mark exactly the toggled output lines
  a_r5_chg_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_chg == (gpio_out ^ $past(gpio_out))));

  // R7: without a direction or level write the outputs do not move
  a_r7_ext_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> ($stable(gpio_out) && gpio_chg == '0));
endmodule

// File: rtl/comp_gpio_regs.sv
module comp_gpio_regs
  import comp_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_GPIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_GPIO-1:0] ext_upd,
  input  logic [N_GPIO-1:0] ext_val,
  output logic [N_GPIO-1:0] gpio_out,
  output logic [N_GPIO-1:0] gpio_chg
);
  reg_id_e          acc_id;
  logic [REG_W-1:0] wr16;
  logic             unused_wdata_hi;

  assign wr16            = bus_wdata[REG_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

  cr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .id   (acc_id)
  );

  logic [REG_W-1:0] mode_q, cdet_q, pwr_q, cctl_q, irr_q, imr_q, isr_q, grd_q;

  cr_ctrl_bank #(
    .W        (REG_W),
    .TRIG_BIT (PWR_TRIG_BIT),
    .SET_MASK (PWR_SET_MASK)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .wr_id   (acc_id),
    .wr_data (wr16),
    .mode_q  (mode_q),
    .cdet_q  (cdet_q),
    .pwr_q   (pwr_q),
    .cctl_q  (cctl_q),
    .irr_q   (irr_q),
    .imr_q   (imr_q),
    .isr_q   (isr_q),
    .grd_q   (grd_q)
  );

  logic [N_GPIO-1:0] dir_q, lvl_q;

  cr_gpio_port #(.N(N_GPIO)) u_gpio (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_we   (bus_we && acc_id == RID_GDIR),
    .lvl_we   (bus_we && acc_id == RID_GLVL),
    .wr_data  (wr16[N_GPIO-1:0]),
    .ext_upd  (ext_upd),
    .ext_val  (ext_val),
    .dir_q    (dir_q),
    .lvl_q    (lvl_q),
    .gpio_out (gpio_out),
    .gpio_chg (gpio_chg)
  );

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    case (acc_id)
      RID_MODE: rd_mux = mode_q;
      RID_CDET: rd_mux = cdet_q;
      RID_STAT: rd_mux = STAT_RESET;
      RID_PWR:  rd_mux = pwr_q;
      RID_CCTL: rd_mux = cctl_q;
      RID_IRR:  rd_mux = irr_q;
      RID_IMR:  rd_mux = imr_q;
      RID_ISR:  rd_mux = isr_q;
      RID_GDIR: rd_mux = REG_W'(dir_q);
      RID_GLVL: rd_mux = REG_W'(lvl_q);
      RID_GRD:  rd_mux = grd_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  // R8: unmapped or misaligned reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && acc_id == RID_NONE) |=> (bus_rdata == '0));

  // R9: read data holds while no read is issued
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/sim_comp_gpio_regs.sv
module sim_comp_gpio_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [15:0] ext_upd = '0;
  logic [15:0] ext_val = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_chg;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_gpio_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ext_upd(ext_upd), .ext_val(ext_val), .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  // Reference model
  logic [15:0] m_mode, m_cdet, m_pwr, m_cctl, m_irr, m_imr, m_isr, m_dir, m_lvl, m_prev, m_grd;
  logic [15:0] m_chg;

  task automatic model_reset();
    m_mode = 0; m_cdet = 0; m_pwr = 0; m_cctl = 0; m_irr = 0; m_imr = 0;
    m_isr = 0; m_dir = 0; m_lvl = 0; m_prev = 0; m_grd = 0; m_chg = 0;
  endtask

  function automatic logic [15:0] exp_read(logic [11:0] off);
    case (off)
      12'h000: return m_mode;
      12'h004: return m_cdet;
      12'h008: return 16'h0002;
      12'h00C: return m_pwr;
      12'h010: return m_cctl;
      12'h014: return m_irr;
      12'h018: return m_imr;
      12'h01C: return m_isr;
      12'h020: return m_dir;
      12'h024: return m_lvl;
      12'h028: return m_grd;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pwr_rule(logic [15:0] d);
    return d[7] ? (d | 16'h8040) : d;
  endfunction

  task automatic model_refresh();
    logic [15:0] eff;
    eff    = m_lvl & m_dir;
    m_chg  = eff ^ m_prev;
    m_prev = eff;
  endtask

  task automatic model_write(logic [11:0] off, logic [31:0] data);
    logic [15:0] d;
    d = data[15:0];
    m_chg = 0;
    case (off)
      12'h000: m_mode = d;
      12'h004: m_cdet = d;
      12'h00C: m_pwr  = pwr_rule(d);
      12'h010: m_cctl = d;
      12'h014: m_irr  = d;
      12'h018: m_imr  = d;
      12'h01C: m_isr  = d;
      12'h020: begin m_dir = d; model_refresh(); end
      12'h024: begin m_lvl = d & m_dir; model_refresh(); end
      12'h028: m_grd  = d;
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic do_write(string req, logic [11:0] off, logic [31:0] data);
    @(negedge clk);
    bus_addr = off; bus_wdata = data; bus_we = 1'b1;
    model_write(off, data);
    @(negedge clk);
    bus_we = 1'b0;
    check({req, " gpio_out"}, gpio_out, m_prev);
    check({req, " gpio_chg"}, gpio_chg, m_chg);
  endtask

  task automatic do_read(string req, logic [11:0] off);
    @(negedge clk);
    bus_addr = off; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, bus_rdata, exp_read(off));
  endtask

  task automatic do_ext(logic [15:0] upd, logic [15:0] val);
    logic [15:0] out_before;
    @(negedge clk);
    out_before = gpio_out;
    ext_upd = upd; ext_val = val;
    m_lvl = (m_lvl & ~upd) | (val & upd);
    @(negedge clk);
    ext_upd = '0;
    check("R7 ext keeps gpio_out", gpio_out, out_before);
    check("R7 ext no gpio_chg", gpio_chg, 16'h0000);
  endtask

  function automatic logic [11:0] pick_off(int k);
    case (k)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;  3: return 12'h00C;
      4: return 12'h010;  5: return 12'h014;  6: return 12'h018;  7: return 12'h01C;
      8: return 12'h020;  9: return 12'h024; 10: return 12'h028; 11: return 12'h02C;
      12: return 12'h002; 13: return 12'h7FC; 14: return 12'hFFC; default: return 12'h030;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset values over the whole map
    check("R6 reset gpio_out", gpio_out, 16'h0000);
    check("R6 reset gpio_chg", gpio_chg, 16'h0000);
    for (int k = 0; k < 11; k++) do_read("R6 reset read", pick_off(k));

    // R2: upper data bits discarded
    do_write("R2", 12'h000, 32'hABCD_1234);
    do_read("R2 mode low half", 12'h000);
    // R3: power rule, with and without trigger bit
    do_write("R3", 12'h00C, 32'h0000_0080);
    do_read("R3 power trig", 12'h00C);
    check("R3 power value", exp_read(12'h00C), 16'h80C0);
    do_write("R3", 12'h00C, 32'h0000_1234);
    do_read("R3 power plain", 12'h00C);
    // R4 and R5: masked level write and change pulses
    do_write("R5 dir", 12'h020, 32'h0000_00FF);
    do_write("R4 lvl", 12'h024, 32'h0000_FFFF);
    do_read("R4 lvl masked", 12'h024);
    do_write("R5 dir shrink", 12'h020, 32'h0000_000F);
    do_write("R5 dir grow", 12'h020, 32'h0000_FFFF);
    // R7: external updates, then bus level write wins over simultaneous ext
    do_ext(16'hF000, 16'hA000);
    do_read("R7 lvl after ext", 12'h024);
    do_write("R7 refresh after ext", 12'h020, 32'h0000_FFFF);
    @(negedge clk);
    bus_addr = 12'h024; bus_wdata = 32'h0000_00F0; bus_we = 1'b1;
    ext_upd = 16'h0101; ext_val = 16'h0101;
    model_write(12'h024, 32'h0000_00F0);
    @(negedge clk);
    bus_we = 1'b0; ext_upd = '0;
    check("R7 bus wins gpio_out", gpio_out, m_prev);
    do_read("R7 bus wins lvl", 12'h024);
    // R8: status and unmapped writes ignored, unmapped reads zero
    do_write("R8 status wr", 12'h008, 32'h0000_FFFF);
    do_write("R8 unmapped wr", 12'h02C, 32'h0000_FFFF);
    do_write("R8 misaligned wr", 12'h001, 32'h0000_5555);
    for (int k = 0; k < 16; k++) do_read("R8 map after ignored writes", pick_off(k));
    // R9: data lands one clock after read enable and holds without it
    do_read("R9 first", 12'h000);
    @(negedge clk);
    bus_addr = 12'h024; bus_re = 1'b1;
    #1 check("R9 not yet updated", bus_rdata, exp_read(12'h000));
    @(negedge clk);
    bus_re = 1'b0;
    check("R9 updated", bus_rdata, exp_read(12'h024));
    bus_addr = 12'h000;
    repeat (2) @(negedge clk);
    check("R9 holds", bus_rdata, exp_read(12'h024));

    // R1 R5 R7: random mix of writes, reads and external updates
    for (int n = 0; n < 600; n++) begin
      int op;
      int k;
      op = int'($urandom % 10);
      k  = int'($urandom % 16);
      if (op < 2)      do_ext(16'($urandom), 16'($urandom));
      else if (op < 4) do_write("R5 rand gpio", (op == 2) ? 12'h020 : 12'h024, $urandom);
      else if (op < 7) do_write("R1 rand wr", pick_off(k), $urandom);
      else             do_read("R1 rand rd", pick_off(k));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule